// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits behind the bit-level front end of a two-wire serial memory. The front end reports protocol events: a new start, the loading of a word address, each received data byte, and the stop condition together with a flag that says whether the stop followed a data-byte acknowledge at once. The block gathers the received bytes in a page buffer, one slot for each value of the low address byte. It marks each slot that received a byte, and on a valid stop it starts a timed programming cycle.

During the programming cycle the block raises `busy` for a fixed number of system clocks. It walks the page once, starting at the loaded address, and issues one memory write pulse for each marked slot. The page part of the address (all bits above the low byte) is the same for every write. Every command input is ignored while the cycle runs. A stop that does not qualify discards the collected bytes. A write-protect or low-supply flag seen at the stop also discards them.

Top module: `page_commit_unit`

## Requirements
- R1: After reset `busy` and `mem_we` are 0.
- R2: Each accepted data byte goes to the slot given by the low `LOW_W` bits of the running pointer, and the pointer then steps by one and wraps from all-ones to zero. The bits of `mem_addr` above the low byte always equal those of the last loaded address.
- R3: If more than 2^`LOW_W` bytes arrive, later bytes overwrite earlier ones in the same slot. Each slot is written at most once per cycle and carries the last byte received for it.
- R4: A cycle starts only if at least one byte was accepted since the last clear and `stop_after_ack`=1 at the stop. Any other stop clears the collected bytes, and no cycle starts.
- R5: During a cycle, the marked slot at offset j from the loaded low address is written in busy cycle j+1 (cycle 0 is the first busy cycle). Unmarked slots are never written.
- R6: `busy` rises the cycle after a committing stop and stays high for exactly `WR_CYCLES` cycles. `mem_we` is only ever high while `busy` is high.
- R7: If `low_supply`=1 at the stop, no cycle starts and the bytes are discarded.
- R8: If `wp`=1 at the stop, no cycle starts and the bytes are discarded.
- R9: A `start_evt` before the stop clears all bytes collected so far.
- R10: While `busy` is high, `start_evt`, `addr_load`, `byte_vld` and `stop_evt` have no effect. At the end of a cycle the collected bytes are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | One-cycle pulse: new start condition seen |
| addr_load | input | 1 | One-cycle pulse: load `load_addr` as base and pointer |
| load_addr | input | ADDR_W | Full word address (page bits and low byte) |
| byte_vld | input | 1 | One-cycle pulse: `byte_data` is a received data byte |
| byte_data | input | DATA_W | Received data byte |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen |
| stop_after_ack | input | 1 | Stop came right after a data-byte acknowledge |
| wp | input | 1 | Write protect level |
| low_supply | input | 1 | Supply below the safe programming level |
| mem_we | output | 1 | Array write strobe (registered) |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming cycle in progress |

## Verification
The assertions check on every cycle that a write strobe appears only while busy and that the page bits stay fixed. They also check that no cycle writes more than one page of bytes, that a rising busy traces back to a stop with collected data and with neither protect nor low supply, and that each busy window has exactly the configured length. Some behaviour only the bench scenarios can show. That covers the data and slot order of the writes, the last-wins rollover, a discard on a stop in the wrong phase, a start that clears mid-command, and inputs that are ignored during a cycle. The bench shows these by comparing the outputs with its reference model on every clock.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [0:0] {
    PH_COLLECT = 1'b0,
    PH_PROGRAM = 1'b1
  } pcu_phase_e;
endpackage

// File: rtl/pcu_page_ram.sv
module pcu_page_ram #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] store [DEPTH];

  // simple dual-port form: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
    rd_data <= store[rd_idx];
  end
endmodule

// File: rtl/pcu_fill_tracker.sv
module pcu_fill_tracker #(
  parameter int LOW_W  = 8,
  parameter int ADDR_W = 17
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept,
  input  logic                   clr,
  input  logic                   addr_load,
  input  logic [ADDR_W-1:0]      load_addr,
  input  logic                   byte_vld,
  output logic                   wr_en,
  output logic [LOW_W-1:0]       wr_idx,
  output logic [(1<<LOW_W)-1:0]  marks,
  output logic [ADDR_W-1:0]      base_addr,
  output logic                   have_byte
);
  logic [LOW_W-1:0] ptr;

  assign wr_en  = accept && byte_vld;
  assign wr_idx = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      marks     <= '0;
      ptr       <= '0;
      base_addr <= '0;
      have_byte <= 1'b0;
    end else begin
      if (clr) begin
        marks     <= '0;
        have_byte <= 1'b0;
      end
      if (accept && addr_load) begin
        base_addr <= load_addr;
        ptr       <= load_addr[LOW_W-1:0];
      end
      if (wr_en) begin
        marks[ptr] <= 1'b1;
        ptr        <= ptr + 1'b1;   // wraps inside the page
        have_byte  <= 1'b1;
      end
    end
  end

  // R2: a byte outside a load cycle always advances the pointer by one
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_load) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/pcu_commit_seq.sv
module pcu_commit_seq
  import pcu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOW_W     = 8,
  parameter int ADDR_W    = 17,
  parameter int WR_CYCLES = 50000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stop_evt,
  input  logic                   stop_after_ack,
  input  logic                   wp,
  input  logic                   low_supply,
  input  logic                   have_byte,
  input  logic [(1<<LOW_W)-1:0]  marks,
  input  logic [ADDR_W-1:0]      base_addr,
  input  logic [DATA_W-1:0]      rd_data,
  output logic [LOW_W-1:0]       rd_idx,
  output logic                   busy,
  output logic                   done,
  output logic                   discard,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata
);
  localparam int PAGE  = 1 << LOW_W;
  localparam int HI_W  = ADDR_W - LOW_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] PAGE_C = CNT_W'(PAGE);

  pcu_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic [LOW_W-1:0] lo_base, lo_q;
  logic [HI_W-1:0]  hi_q;
  logic             we_q, go, scan;

  assign busy    = (phase == PH_PROGRAM);
  assign go      = !busy && stop_evt && stop_after_ack && have_byte && !low_supply && !wp;
  assign discard = !busy && stop_evt && !go;
  assign done    = busy && (cnt == LAST_C);
  assign scan    = busy && (cnt < PAGE_C);
  assign rd_idx  = lo_base + cnt[LOW_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_COLLECT;
      cnt     <= '0;
      lo_base <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= scan && marks[rd_idx];
      lo_q <= rd_idx;
      if (go) begin
        phase   <= PH_PROGRAM;
        cnt     <= '0;
        hi_q    <= base_addr[ADDR_W-1:LOW_W];
        lo_base <= base_addr[LOW_W-1:0];
      end else if (busy) begin
        if (done) begin
          phase <= PH_COLLECT;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = {hi_q, lo_q};
  assign mem_wdata = rd_data;

  // checker counter for the busy window length
  logic [CNT_W-1:0] chk_len;
  always_ff @(posedge clk) begin
    if (rst) chk_len <= '0;
    else     chk_len <= busy ? chk_len + 1'b1 : '0;
  end

  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(chk_len) == LAST_C));
  p_busy_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_evt && have_byte && stop_after_ack));
  p_lowvdd_block_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(low_supply));
  p_protect_block_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(wp));
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int DATA_W    = 8,
  parameter int LOW_W     = 8,
  parameter int ADDR_W    = 17,
  parameter int WR_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              stop_after_ack,
  input  logic              wp,
  input  logic              low_supply,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  localparam int PAGE = 1 << LOW_W;

  logic              wr_en, have_byte, done, discard, clr;
  logic [LOW_W-1:0]  wr_idx, rd_idx;
  logic [PAGE-1:0]   marks;
  logic [ADDR_W-1:0] base_addr;
  logic [DATA_W-1:0] rd_data;

  assign clr = (!busy && start_evt) || discard || done;

  pcu_fill_tracker #(.LOW_W(LOW_W), .ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst(rst), .accept(!busy), .clr(clr),
    .addr_load(addr_load), .load_addr(load_addr), .byte_vld(byte_vld),
    .wr_en(wr_en), .wr_idx(wr_idx), .marks(marks),
    .base_addr(base_addr), .have_byte(have_byte)
  );

  pcu_page_ram #(.DATA_W(DATA_W), .IDX_W(LOW_W)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(byte_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  pcu_commit_seq #(.DATA_W(DATA_W), .LOW_W(LOW_W), .ADDR_W(ADDR_W),
                   .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .stop_evt(stop_evt), .stop_after_ack(stop_after_ack),
    .wp(wp), .low_supply(low_supply), .have_byte(have_byte), .marks(marks),
    .base_addr(base_addr), .rd_data(rd_data), .rd_idx(rd_idx), .busy(busy),
    .done(done), .discard(discard), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  // per-cycle write count, checker only
  logic [LOW_W+1:0] wcnt;
  always_ff @(posedge clk) begin
    if (rst) wcnt <= '0;
    else     wcnt <= busy ? wcnt + {{(LOW_W+1){1'b0}}, mem_we} : '0;
  end

  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  p_page_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:LOW_W] == base_addr[ADDR_W-1:LOW_W]));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    wcnt <= (LOW_W+2)'(PAGE));
endmodule

// File: tb/test_page_commit_unit.sv
module test_page_commit_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 300;

  logic clk = 1'b0, rst = 1'b1;
  logic start_evt = 0, addr_load = 0, byte_vld = 0, stop_evt = 0;
  logic stop_after_ack = 0, wp = 0, low_supply = 0;
  logic [16:0] load_addr = '0;
  logic [7:0]  byte_data = '0;
  logic        mem_we, busy;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;

  int errors = 0, checks = 0, wr_seen = 0, busy_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_commit_unit #(.WR_CYCLES(W)) i_page_commit_unit (
    .clk(clk), .rst(rst), .start_evt(start_evt), .addr_load(addr_load),
    .load_addr(load_addr), .byte_vld(byte_vld), .byte_data(byte_data),
    .stop_evt(stop_evt), .stop_after_ack(stop_after_ack), .wp(wp),
    .low_supply(low_supply), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  // behavioural reference model
  bit   mk [256];
  logic [7:0] md [256];
  int   base = 0, ptr = 0, mc = -1;
  bit   got = 0;

  function automatic void clear_model();
    foreach (mk[i]) mk[i] = 0;
    got = 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      clear_model(); mc = -1; base = 0; ptr = 0;
    end else if (mc >= 0) begin
      mc++;
      if (mc == W) begin mc = -1; clear_model(); end
    end else begin
      if (start_evt) clear_model();
      if (addr_load) begin base = int'(load_addr); ptr = base % 256; end
      if (byte_vld) begin mk[ptr] = 1; md[ptr] = byte_data; ptr = (ptr + 1) % 256; got = 1; end
      if (stop_evt) begin
        if (got && stop_after_ack && !low_supply && !wp) mc = 0;
        else clear_model();
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit ew; int idx;
      idx = (base + mc - 1) % 256;
      if (idx < 0) idx += 256;
      ew = (mc >= 1) && (mc <= 256) && mk[idx];
      check(busy == (mc >= 0), "R6 busy", int'(busy), int'(mc >= 0));
      check(mem_we == ew, "R5 mem_we", int'(mem_we), int'(ew));
      if (ew && mem_we) begin
        check(int'(mem_addr) == ((base / 256) * 256 + idx), "R2 mem_addr",
              int'(mem_addr), (base / 256) * 256 + idx);
        check(mem_wdata == md[idx], "R3 mem_wdata", int'(mem_wdata), int'(md[idx]));
      end
      if (mem_we) wr_seen++;
      if (busy) busy_seen++;
    end
  end

  task automatic pulse_start(); start_evt = 1; @(negedge clk); start_evt = 0; endtask
  task automatic pulse_load(input logic [16:0] a);
    load_addr = a; addr_load = 1; @(negedge clk); addr_load = 0;
  endtask
  task automatic pulse_byte(input logic [7:0] d);
    byte_data = d; byte_vld = 1; @(negedge clk); byte_vld = 0;
  endtask
  task automatic pulse_stop(input logic tag);
    stop_after_ack = tag; stop_evt = 1; @(negedge clk); stop_evt = 0; stop_after_ack = 0;
  endtask
  task automatic expect_run(input int n_wr, input bit want_busy, input string req);
    int w0 = wr_seen, b0 = busy_seen;
    repeat (W + 8) @(negedge clk);
    check(wr_seen - w0 == n_wr, req, wr_seen - w0, n_wr);
    check((busy_seen - b0 == W) == want_busy || (!want_busy && busy_seen == b0), req,
          busy_seen - b0, want_busy ? W : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy == 0 && mem_we == 0, "R1 reset", int'({busy, mem_we}), 0);

    // R5: single byte
    pulse_start(); pulse_load(17'h1_2340); pulse_byte(8'hA5); pulse_stop(1);
    expect_run(1, 1, "R5 single byte");

    // R2: wrap of the low byte inside the page
    pulse_start(); pulse_load(17'h0_45FE);
    for (int i = 0; i < 5; i++) pulse_byte(8'h10 + 8'(i));
    pulse_stop(1);
    expect_run(5, 1, "R2 low wrap");

    // R3: 300 bytes, last 256 win
    pulse_start(); pulse_load(17'h1_AA10);
    for (int i = 0; i < 300; i++) pulse_byte(8'(i * 7));
    pulse_stop(1);
    expect_run(256, 1, "R3 rollover");

    // R4: stop not after data ack, then stop with nothing collected
    pulse_start(); pulse_load(17'h0_0100); pulse_byte(8'h33); pulse_stop(0);
    expect_run(0, 0, "R4 wrong phase");
    pulse_stop(1);
    expect_run(0, 0, "R4 empty after discard");

    // R7: low supply at stop
    pulse_start(); pulse_load(17'h0_0200); pulse_byte(8'h44);
    low_supply = 1; pulse_stop(1); low_supply = 0;
    expect_run(0, 0, "R7 low supply");

    // R8: write protect at stop
    pulse_start(); pulse_load(17'h0_0300); pulse_byte(8'h55);
    wp = 1; pulse_stop(1); wp = 0;
    expect_run(0, 0, "R8 protect");

    // R9: restart clears earlier bytes
    pulse_start(); pulse_load(17'h0_0400); pulse_byte(8'h66); pulse_byte(8'h67);
    pulse_byte(8'h68);
    pulse_start(); pulse_load(17'h0_0480); pulse_byte(8'h77); pulse_byte(8'h78);
    pulse_stop(1);
    expect_run(2, 1, "R9 restart");

    // R10: commands during busy are ignored; buffer empty afterwards
    pulse_start(); pulse_load(17'h1_0F00); pulse_byte(8'h99); pulse_stop(1);
    repeat (5) @(negedge clk);
    pulse_start(); pulse_load(17'h0_0000); pulse_byte(8'h11); pulse_byte(8'h12);
    pulse_stop(1);
    repeat (W) @(negedge clk);
    check(busy == 0, "R10 busy ended", int'(busy), 0);
    pulse_stop(1);
    expect_run(0, 0, "R10 nothing kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule